// File: doc/BRIEF.md
# Knock-Sequence Window Relocator

This block watches host I/O writes aimed at one fixed trigger address and listens for a short ASCII passphrase spelled out one byte per write. Once the passphrase has been heard in full, the two trigger writes that follow carry a new 16-bit base address, low byte first, for a separate two-address register window. The base is replaced only when both bytes have arrived, so the window never sits at a half-updated address.

The block drives the current base and a flag that says whether the window is mapped. The all-ones base means "no window"; this is the reset value. A decoder elsewhere compares host addresses against the base and the base plus one; that decode, and any read path, belong to other logic.

Both the passphrase detector and the base loader see every trigger write. The loader acts on a byte first and the detector second, so the byte that finishes the passphrase only arms the loader and is never taken as a base byte. Base bytes also feed the detector like any other trigger write.

Top module: `knock_relocator`

## Requirements
- R1: After a synchronous, active-high reset, the base output is 0xFFFF and the mapped flag is low.
- R2: Writes to any address other than 0x0080, and cycles with the write strobe low, change neither the base nor the progress of the passphrase detector.
- R3: After the trigger writes '8' (0x38), '6' (0x36), 'B' (0x42), 'o' (0x6F), 'x' (0x78) in that order, the next trigger write is the base low byte and the one after it the high byte; the base output shows {high, low} in the cycle after the high-byte write.
- R4: After the low-byte write alone the base output keeps its old value.
- R5: A trigger byte that is not the next expected passphrase character sends the detector back to expecting '8', so a broken passphrase followed by two bytes loads no base.
- R6: A '8' always moves the detector to expecting '6', whatever it was expecting, so "8 6 8 6 B o x" is a valid passphrase.
- R7: The mapped flag is high exactly when the base is not 0xFFFF, and it follows the base in the same cycle; loading 0xFFFF unmaps the window and loading 0x0000 maps it.
- R8: After a commit the loader is idle: further trigger writes without a new passphrase leave the base unchanged.
- R9: Base bytes are also seen by the detector, so base bytes '8','6' followed by "B o x" and two more bytes commit two bases in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioWrite | input | 1 | Host I/O write strobe, one cycle per write |
| ioAddr | input | 16 | Host I/O address |
| ioData | input | 8 | Host I/O write data |
| windowBase | output | 16 | Committed base of the two-address window, 0xFFFF when unmapped |
| windowValid | output | 1 | High when the window is mapped |

## Verification
Every write is registered on one clock edge, so the base and the mapped flag reflect a high-byte write one cycle after the strobe, and any earlier write's effect is only internal. The bench drives each write on a falling edge, holds it across exactly one rising edge, drops the strobe on the next falling edge and samples the outputs there, which is the first point the result is due. Checks of the "no effect" kind are made by following the suspect stimulus with bytes that would load a base if the detector or loader had been disturbed, then reading the base at the ports.

// File: rtl/knock_pkg.sv
package knock_pkg;

  localparam int KNOCK_LEN = 5;

  typedef enum logic [1:0] {
    LD_IDLE    = 2'd0,
    LD_WAIT_LO = 2'd1,
    LD_WAIT_HI = 2'd2
  } loadState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLo;
    logic commit;
  } baseCtl_t;

  // passphrase characters by position
  function automatic logic [7:0] knockChar(input int unsigned idx);
    case (idx)
      0: knockChar = 8'h38;
      1: knockChar = 8'h36;
      2: knockChar = 8'h42;
      3: knockChar = 8'h6F;
      4: knockChar = 8'h78;
      default: knockChar = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/knock_ctrl.sv
module knock_ctrl
  import knock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TRIGGER_ADDR = 16'h0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  output baseCtl_t          ctl
);

  localparam int IDX_W = $clog2(KNOCK_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KNOCK_LEN - 1);

  logic             trigWrite;
  logic [IDX_W-1:0] knockIdx, idxNext;
  loadState_e       loadState, loadNext;
  logic             armLoad;

  assign trigWrite = ioWrite && (ioAddr == TRIGGER_ADDR);

  always_comb begin
    ctl      = '0;
    loadNext = loadState;
    idxNext  = knockIdx;
    armLoad  = 1'b0;
    if (trigWrite) begin
      // loader acts first
      case (loadState)
        LD_WAIT_LO: begin
          ctl.latchLo = 1'b1;
          loadNext    = LD_WAIT_HI;
        end
        LD_WAIT_HI: begin
          ctl.commit = 1'b1;
          loadNext   = LD_IDLE;
        end
        default: loadNext = LD_IDLE;
      endcase
      // then the passphrase detector
      if (ioData == DATA_W'(knockChar(0))) begin
        idxNext = IDX_W'(1);
      end else if (ioData == DATA_W'(knockChar(int'(knockIdx)))) begin
        if (knockIdx == LAST_IDX) begin
          idxNext = '0;
          armLoad = 1'b1;
        end else begin
          idxNext = knockIdx + IDX_W'(1);
        end
      end else begin
        idxNext = '0;
      end
      if (armLoad) loadNext = LD_WAIT_LO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      knockIdx  <= '0;
      loadState <= LD_IDLE;
    end else begin
      knockIdx  <= idxNext;
      loadState <= loadNext;
    end
  end

  // the high-byte stage is only ever entered from a low-byte latch
  p_hi_follows_lo_r3 : assert property (@(posedge clk) disable iff (rst)
    (loadState == LD_WAIT_HI && $past(loadState) != LD_WAIT_HI) |-> $past(ctl.latchLo));

  // strobes only accompany a trigger write
  p_strobe_on_trigger_r2 : assert property (@(posedge clk) disable iff (rst)
    (ctl.latchLo || ctl.commit) |-> (ioWrite && ioAddr == TRIGGER_ADDR));

endmodule

// File: rtl/knock_base.sv
module knock_base
  import knock_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  baseCtl_t          ctl,
  input  logic [DATA_W-1:0] ioData,
  output logic [ADDR_W-1:0] windowBase,
  output logic              windowValid
);

  localparam logic [ADDR_W-1:0] UNMAPPED = '1;

  logic [DATA_W-1:0] lowByte;
  logic [ADDR_W-1:0] baseReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowByte <= '0;
      baseReg <= UNMAPPED;
    end else begin
      if (ctl.latchLo) lowByte <= ioData;
      if (ctl.commit)  baseReg <= {ioData, lowByte};
    end
  end

  assign windowBase  = baseReg;
  assign windowValid = (baseReg != UNMAPPED);

  // the base only moves on a commit strobe
  p_base_holds_r4 : assert property (@(posedge clk) disable iff (rst)
    !ctl.commit |=> $stable(windowBase));

endmodule

// File: rtl/knock_relocator.sv
module knock_relocator
  import knock_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] TRIGGER_ADDR = 16'h0080
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ioWrite,
  input  logic [2*DATA_W-1:0] ioAddr,
  input  logic [DATA_W-1:0]   ioData,
  output logic [2*DATA_W-1:0] windowBase,
  output logic                windowValid
);

  localparam int ADDR_W = 2 * DATA_W;

  baseCtl_t ctl;

  knock_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TRIGGER_ADDR(TRIGGER_ADDR)
  ) uCtrl (
    .clk(clk),
    .rst(rst),
    .ioWrite(ioWrite),
    .ioAddr(ioAddr),
    .ioData(ioData),
    .ctl(ctl)
  );

  knock_base #(
    .DATA_W(DATA_W)
  ) uBase (
    .clk(clk),
    .rst(rst),
    .ctl(ctl),
    .ioData(ioData),
    .windowBase(windowBase),
    .windowValid(windowValid)
  );

  p_reset_unmapped_r1 : assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (windowBase == '1 && !windowValid));

  p_ignore_other_r2 : assert property (@(posedge clk) disable iff (rst)
    !(ioWrite && ioAddr == TRIGGER_ADDR) |=> $stable(windowBase));

endmodule

// File: tb/tb_knock_relocator.sv
module tb_knock_relocator;

  logic        clk = 1'b0;
  logic        rst;
  logic        ioWrite;
  logic [15:0] ioAddr;
  logic [7:0]  ioData;
  logic [15:0] windowBase;
  logic        windowValid;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  knock_relocator dut (
    .clk(clk), .rst(rst), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioData(ioData), .windowBase(windowBase), .windowValid(windowValid)
  );

  task automatic check(input string tag, input logic [15:0] expBase, input logic expValid);
    checks++;
    if (windowBase !== expBase || windowValid !== expValid) begin
      fails++;
      $display("FAIL %s: base=%h valid=%b expected base=%h valid=%b",
               tag, windowBase, windowValid, expBase, expValid);
    end
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    ioWrite = 1'b1; ioAddr = addr; ioData = data;
    @(negedge clk);
    ioWrite = 1'b0;
  endtask

  task automatic trig(input logic [7:0] data);
    wr(16'h0080, data);
  endtask

  task automatic knock();
    trig(8'h38); trig(8'h36); trig(8'h42); trig(8'h6F); trig(8'h78);
  endtask

  task automatic t_reset();
    check("R1 reset base", 16'hFFFF, 1'b0);
  endtask

  task automatic t_basic();
    knock();
    trig(8'h34);
    check("R4 low byte alone", 16'hFFFF, 1'b0);
    trig(8'h12);
    check("R3 commit", 16'h1234, 1'b1);
  endtask

  task automatic t_ignore();
    wr(16'h0081, 8'h38); wr(16'h0180, 8'h36);
    @(negedge clk); ioAddr = 16'h0080; ioData = 8'h99; ioWrite = 1'b0;
    @(negedge clk);
    check("R2 foreign writes", 16'h1234, 1'b1);
    trig(8'h38); trig(8'h36);
    wr(16'h0081, 8'h00); wr(16'h0000, 8'h42);
    trig(8'h42); trig(8'h6F);
    @(negedge clk); ioAddr = 16'h0080; ioData = 8'h55; ioWrite = 1'b0;
    @(negedge clk);
    trig(8'h78);
    trig(8'h00); trig(8'h11);
    check("R2 detector undisturbed", 16'h1100, 1'b1);
  endtask

  task automatic t_broken();
    trig(8'h38); trig(8'h36); trig(8'h42); trig(8'h58); trig(8'h6F); trig(8'h78);
    trig(8'h55); trig(8'h66);
    check("R5 wrong char", 16'h1100, 1'b1);
    trig(8'h38); trig(8'h36); trig(8'h42); trig(8'h6F); trig(8'h79); trig(8'h78);
    trig(8'h77); trig(8'h88);
    check("R5 wrong last char", 16'h1100, 1'b1);
  endtask

  task automatic t_restart();
    trig(8'h38); trig(8'h36); trig(8'h38); trig(8'h36);
    trig(8'h42); trig(8'h6F); trig(8'h78);
    trig(8'h9A); trig(8'hBC);
    check("R6 restart on 8", 16'hBC9A, 1'b1);
  endtask

  task automatic t_idle_after();
    trig(8'h22); trig(8'h33);
    check("R8 idle after commit", 16'hBC9A, 1'b1);
    trig(8'h78); trig(8'h44); trig(8'h45);
    check("R8 lone x", 16'hBC9A, 1'b1);
  endtask

  task automatic t_overlap();
    knock();
    trig(8'h38); trig(8'h36);
    check("R9 first commit", 16'h3638, 1'b1);
    trig(8'h42); trig(8'h6F); trig(8'h78);
    trig(8'h01); trig(8'h02);
    check("R9 second commit", 16'h0201, 1'b1);
  endtask

  task automatic t_unmap();
    knock(); trig(8'hFF); trig(8'hFF);
    check("R7 unmap", 16'hFFFF, 1'b0);
    knock(); trig(8'h00); trig(8'h00);
    check("R7 zero base mapped", 16'h0000, 1'b1);
    knock(); trig(8'hFF); trig(8'hFE);
    check("R7 near unmapped", 16'hFEFF, 1'b1);
  endtask

  initial begin
    rst = 1'b1; ioWrite = 1'b0; ioAddr = '0; ioData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignore();
    t_broken();
    t_restart();
    t_idle_after();
    t_overlap();
    t_unmap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule